// File: doc/BRIEF.md
# Vertical-Crosswise Array Multiplier

This block is a purely combinational unsigned multiplier. It takes two operands of `WIDTH` bits each and returns their full product of `2*WIDTH` bits, with no truncation. The smallest unit is an 8x8 cell. The cell first forms all 64 single-bit cross terms at the same time, each as the AND of one bit from each operand. It then adds the product one column at a time. Each column collects its vertical and crosswise terms, adds in the carry count from the column below, keeps the low bit as the product bit, and passes the remaining count up to the next column.

Wider multipliers are built by recursion. At each level both operands are split into a high half and a low half. Four half-width multipliers form the high-high, high-low, low-high and low-low products. The two cross products are added together, and the three terms are then combined with shifted additions. The block has no clock and no state. It sits on a datapath between registers owned by the surrounding logic, and the product follows the operands within the same evaluation.

Top module: `vc_multiplier`

## Requirements
- R1: `product` equals the unsigned product of `op_a` and `op_b`, taken at full `2*WIDTH`-bit precision, for every pair of operand values.
- R2: `WIDTH` must be 8 times a power of two (8, 16, 32, 64, and so on). With `WIDTH` = 8 the block is a single column cell, and with `WIDTH` = 8 it is checked exhaustively over all 65536 operand pairs.
- R3: Bit 0 of `product` equals `op_a[0] AND op_b[0]`.
- R4: When either operand is zero, `product` is zero.
- R5: When one operand is 1, `product` equals the other operand, zero-extended.
- R6: When both operands are all ones, `product` equals 2^(2W) − 2^(W+1) + 1. This means bit 0 is 1, bits 1 to W are 0, and bits W+1 to 2W−1 are 1. No carry beyond the top product bit corrupts the result.
- R7: When both operands have their top bit clear, the two top bits of `product` (bits 2W−1 and 2W−2) are zero.
- R8: The block is combinational. A change on either operand is reflected on `product` in the same time step, with no clock edge in between.
- R9: Swapping `op_a` and `op_b` leaves `product` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | Unsigned multiplicand |
| op_b | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Full unsigned product |

## Verification
The assertions are immediate checks inside a combinational process. They assume the operands carry only 0 and 1 values whenever they are evaluated, so every assertion is guarded to skip any operand or product value that holds X or Z. The bench drives both operands together from a single task and then waits a short delay before sampling. Because of this, no check ever sees a half-updated operand pair. The width assertion is checked once, at time zero, against the parameter value only.

// File: rtl/vcm_pkg.sv
// Package: shared constants and helpers for the vertical-crosswise multiplier.
// Assumes callers pass positive widths.
package vcm_pkg;

    // Width of the leaf column cell.
    localparam int unsigned LEAF_W = 8;

    // True when w is LEAF_W times a power of two.
    function automatic bit width_is_legal(input int unsigned w);
        int unsigned q;
        if (w < LEAF_W || (w % LEAF_W) != 0) return 1'b0;
        q = w / LEAF_W;
        return (q & (q - 1)) == 0;
    endfunction

    // Number of levels of half-width splitting from w down to LEAF_W.
    function automatic int unsigned split_depth(input int unsigned w);
        int unsigned d;
        int unsigned v;
        d = 0;
        v = w;
        while (v > LEAF_W) begin
            v = v / 2;
            d++;
        end
        return d;
    endfunction

endpackage

// File: rtl/vcm_leaf8.sv
// Module: 8x8 unsigned column multiplier.
// All 64 cross terms are formed in parallel, then each of the 15 columns
// is summed with the carry count from the column below. Any carry above
// product bit 15 is dropped (it is always zero for 8-bit operands).
// Assumes nothing about the operand values.
module vcm_leaf8
    import vcm_pkg::*;
(
    input  logic [LEAF_W-1:0]   x,
    input  logic [LEAF_W-1:0]   y,
    output logic [2*LEAF_W-1:0] p
);

    localparam int unsigned NCOL = 2 * LEAF_W - 1;
    localparam int unsigned SW   = 5;

    logic [LEAF_W-1:0][LEAF_W-1:0] xterm;

    // Cross-term plane: one AND per bit pair, all formed at once.
    for (genvar gi = 0; gi < LEAF_W; gi++) begin : g_row
        for (genvar gj = 0; gj < LEAF_W; gj++) begin : g_col
            assign xterm[gi][gj] = x[gi] & y[gj];
        end
    end

    // Column reduction: sum each column's terms plus the incoming carry count.
    always_comb begin
        logic [SW-1:0]   colsum;
        logic [SW-2:0]   carry;
        carry = '0;
        p     = '0;
        for (int k = 0; k < NCOL; k++) begin
            colsum = {1'b0, carry};
            for (int i = 0; i < LEAF_W; i++) begin
                if ((k - i) >= 0 && (k - i) < LEAF_W) begin
                    colsum = colsum + SW'(xterm[i][3'(k - i)]);
                end
            end
            p[k]  = colsum[0];
            carry = colsum[SW-1:1];
        end
        p[2*LEAF_W-1] = carry[0];
    end

endmodule

// File: rtl/vcm_merge.sv
// Module: recombines four half-width products into one full product.
// result = hh<<(2H) + (hl+lh)<<H + ll, where H is the half operand width.
// Assumes each input is a full 2H-bit product of H-bit halves.
module vcm_merge #(
    parameter int unsigned HALF_W = 8
) (
    input  logic [2*HALF_W-1:0] ll,
    input  logic [2*HALF_W-1:0] lh,
    input  logic [2*HALF_W-1:0] hl,
    input  logic [2*HALF_W-1:0] hh,
    output logic [4*HALF_W-1:0] full
);

    localparam int unsigned MID_W = 2 * HALF_W + 1;

    logic [MID_W-1:0] mid;

    // Cross sum: the two middle partial products, one bit wider.
    assign mid = {1'b0, lh} + {1'b0, hl};

    // Shifted addition of outer pair and middle sum.
    assign full = {hh, ll} + {{(HALF_W-1){1'b0}}, mid, {HALF_W{1'b0}}};

endmodule

// File: rtl/vcm_tree.sv
// Module: recursive multiplier node of width W.
// At W = 8 it is a single leaf cell. Otherwise it splits both operands in
// half and uses four W/2 nodes plus a merge stage.
// Assumes W is 8 times a power of two.
module vcm_tree
    import vcm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);

    localparam int unsigned H = W / 2;

    if (W == LEAF_W) begin : g_leaf
        vcm_leaf8 u_leaf (
            .x (x),
            .y (y),
            .p (p)
        );
    end else begin : g_split
        logic [2*H-1:0] p_ll, p_lh, p_hl, p_hh;

        vcm_tree #(.W(H)) u_ll (.x(x[H-1:0]), .y(y[H-1:0]), .p(p_ll));
        vcm_tree #(.W(H)) u_lh (.x(x[H-1:0]), .y(y[W-1:H]), .p(p_lh));
        vcm_tree #(.W(H)) u_hl (.x(x[W-1:H]), .y(y[H-1:0]), .p(p_hl));
        vcm_tree #(.W(H)) u_hh (.x(x[W-1:H]), .y(y[W-1:H]), .p(p_hh));

        vcm_merge #(.HALF_W(H)) u_merge (
            .ll   (p_ll),
            .lh   (p_lh),
            .hl   (p_hl),
            .hh   (p_hh),
            .full (p)
        );
    end

endmodule

// File: rtl/vc_multiplier.sv
// Module: top of the combinational vertical-crosswise multiplier.
// Returns the full 2*WIDTH-bit unsigned product. It has no clock and no reset.
// Assumes WIDTH is 8 times a power of two; the bound checker flags anything else.
module vc_multiplier
    import vcm_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] product
);

    localparam int unsigned LEVELS = split_depth(WIDTH);

    vcm_tree #(.W(WIDTH)) u_root (
        .x (op_a),
        .y (op_b),
        .p (product)
    );

endmodule

// File: rtl/vc_multiplier_chk.sv
// Module: assertion checker for vc_multiplier, attached by bind.
// Uses immediate checks in a combinational process, since the block has no clock.
// Assumes operands are known (0/1) when checked; unknown values are skipped.
module vc_multiplier_chk
    import vcm_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input logic [WIDTH-1:0]   op_a,
    input logic [WIDTH-1:0]   op_b,
    input logic [2*WIDTH-1:0] product
);

    localparam int unsigned PW = 2 * WIDTH;

    // Parameter legality, checked once.
    initial begin
        a_r2_width_legal: assert (width_is_legal(WIDTH));
    end

    // Functional relations between operands and product.
    always_comb begin
        if (!$isunknown({op_a, op_b, product})) begin
            a_r1_full_product: assert (product == ({{WIDTH{1'b0}}, op_a} * {{WIDTH{1'b0}}, op_b}));
            a_r3_lsb_and: assert (product[0] == (op_a[0] & op_b[0]));
            if (op_a == '0 || op_b == '0) begin
                a_r4_zero_operand: assert (product == '0);
            end
            if (op_a == WIDTH'(1)) begin
                a_r5_unit_operand: assert (product == PW'(op_b));
            end
            if (!op_a[WIDTH-1] && !op_b[WIDTH-1]) begin
                a_r7_top_clear: assert (product[PW-1:PW-2] == 2'b00);
            end
        end
    end

endmodule

bind vc_multiplier vc_multiplier_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product)
);

// File: tb/sim_vc_multiplier.sv
// Bench: directed scenarios for vc_multiplier at WIDTH 64, plus a WIDTH 8 instance
// that is checked exhaustively.
module sim_vc_multiplier;

    localparam int unsigned W  = 64;
    localparam int unsigned W8 = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [W-1:0]    a, b;
    logic [2*W-1:0]  p;
    logic [W8-1:0]   a8, b8;
    logic [2*W8-1:0] p8;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    vc_multiplier #(.WIDTH(W)) u0 (.op_a(a), .op_b(b), .product(p));
    vc_multiplier #(.WIDTH(W8)) u8 (.op_a(a8), .op_b(b8), .product(p8));

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
        return {{W{1'b0}}, x} * {{W{1'b0}}, y};
    endfunction

    task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
        @(negedge clk);
        a = x;
        b = y;
        #1;
    endtask

    // R4: zero on either side
    task automatic t_zero();
        apply('0, 64'hDEAD_BEEF_1234_5678);
        check("R4", p, '0);
        apply(64'hFFFF_FFFF_FFFF_FFFF, '0);
        check("R4", p, '0);
    endtask

    // R5: unit operand passes the other through
    task automatic t_one();
        apply(64'd1, 64'h8000_0000_0000_0001);
        check("R5", p, {64'd0, 64'h8000_0000_0000_0001});
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        check("R5", p, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF});
    endtask

    // R6: all ones both sides
    task automatic t_all_ones();
        logic [2*W-1:0] exp;
        exp = {{(W-1){1'b1}}, {W{1'b0}}, 1'b1};
        apply('1, '1);
        check("R6", p, exp);
    endtask

    // R3 and R7: low bit and clear top bits
    task automatic t_bits();
        apply(64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF);
        check("R7", {126'd0, p[2*W-1:2*W-2]}, '0);
        check("R3", {127'd0, p[0]}, 128'd1);
        apply(64'h0000_0000_0000_0003, 64'hAAAA_AAAA_AAAA_AAAA);
        check("R3", {127'd0, p[0]}, 128'd0);
    endtask

    // R1 and R9: pseudo-random pairs, both orders
    task automatic t_random();
        logic [W-1:0] x, y;
        logic [2*W-1:0] first;
        for (int n = 0; n < 300; n++) begin
            x = {$urandom(), $urandom()};
            y = {$urandom(), $urandom()};
            if (n % 5 == 0) x[W-1:W/2] = '0;
            apply(x, y);
            check("R1", p, ref_mul(x, y));
            first = p;
            apply(y, x);
            check("R9", p, first);
        end
    endtask

    // R8: product follows an operand change with no clock edge
    task automatic t_comb();
        @(posedge clk);
        #1;
        a = 64'h0000_0001_0000_0000;
        b = 64'h0000_0000_0000_0010;
        #1;
        check("R8", p, 128'h10_0000_0000);
        b = 64'h0000_0000_0000_0020;
        #1;
        check("R8", p, 128'h20_0000_0000);
    endtask

    // R2: 8-bit instance, every operand pair
    task automatic t_leaf_exhaustive();
        int bad;
        bad = 0;
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                a8 = 8'(x);
                b8 = 8'(y);
                #1;
                if (p8 !== 16'(x * y)) begin
                    if (bad == 0)
                        $display("FAIL R2: a=%0d b=%0d actual=%0d expected=%0d", x, y, p8, x * y);
                    bad++;
                end
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    initial begin
        a  = '0;
        b  = '0;
        a8 = '0;
        b8 = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #1;
        check("R4", p, '0);
        t_zero();
        t_one();
        t_all_ones();
        t_bits();
        t_comb();
        t_random();
        t_leaf_exhaustive();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule